// File: doc/BRIEF.md
# Carrier Sense Generator with Repeater Mode

This block drives the MII carrier sense output of a 10/100 Mb/s physical layer from two activity indications, one for the receive path and one for the transmit path. In node mode, carrier sense reports activity in either direction. In repeater mode, carrier sense reports receive activity only. A control bit selects the mode, and a strap input sets that bit's value at reset.

Repeater mode changes two more things at 100 Mb/s. It raises the enable for the carrier integrity monitor, which is the logic that flags bad start-of-stream delimiters. It also keeps carrier sense asserted through a long receive jabber. A jabber timer counts unbroken receive activity. When the timer reaches its limit (722 µs by default), the receive contribution to carrier sense is removed until the receive activity ends, unless the repeater hold applies. An override bit cancels the repeater hold. A sticky flag records that a jabber occurred and is cleared by a read strobe.

Top module: `carrier_sense`

## Requirements
- R1: With the repeater bit set and no jabber cut in effect, `crs` equals `rxActive`, and `txActive` has no effect on it.
- R2: With the repeater bit clear (node mode) and no jabber cut in effect, `crs` is `rxActive OR txActive`. In node mode, `txActive` still asserts `crs` during a jabber cut.
- R3: While `rstN` is low, the repeater bit loads `strapRepeater` and the override bit loads 0. A cycle with `cfgWr` high loads `cfgRepeater` and `cfgOverride`, and the new values take effect from the following clock edge.
- R4: `cimEnable` is 1 only when `speed100` is 1 and the repeater bit is set. It is 0 at 10 Mb/s and in node mode.
- R5: Once `rxActive` has been sampled high on JAB_CYCLES consecutive rising edges (JAB_CYCLES = CLK_MHZ*JAB_US), a jabber cut is in effect. In node mode, at either speed, the cut removes the receive contribution to `crs` immediately after that edge.
- R6: In repeater mode at 100 Mb/s with the override bit clear, `crs` stays asserted through a receive jabber of any length.
- R7: With the override bit set, a jabber cut in repeater mode at 100 Mb/s removes the receive contribution to `crs` as in node mode. At 10 Mb/s, a jabber cut applies in repeater mode whatever the override bit holds.
- R8: After a jabber cut, `crs` stays low for as long as `rxActive` stays high. Sampling `rxActive` low on a single edge restarts the count from zero.
- R9: `jabberSeen` rises on the clock edge after a jabber cut begins, in every mode. It stays high until a cycle with `jabRd` high clears it. If a new cut begins in the same cycle as the read, the flag stays set.
- R10: After reset, `jabberSeen` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| strapRepeater | input | 1 | Reset value of the repeater bit |
| speed100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| rxActive | input | 1 | Receive activity indication |
| txActive | input | 1 | Transmit activity indication |
| cfgWr | input | 1 | Load strobe for the mode and override bits |
| cfgRepeater | input | 1 | New repeater bit value |
| cfgOverride | input | 1 | New jabber override bit value |
| jabRd | input | 1 | Read strobe that clears the sticky jabber flag |
| crs | output | 1 | Carrier sense |
| cimEnable | output | 1 | Enable for the carrier integrity monitor |
| jabberSeen | output | 1 | Sticky jabber flag |

## Verification
A vector table covers short bursts over every combination of speed, mode and override, with receive only, transmit only, both, or neither. This separates node-mode carrier sense (transmit counts) from repeater-mode carrier sense (transmit ignored), and it separates monitor enable at 100 Mb/s from 10 Mb/s. Directed receive bursts held past the jabber limit show, for each mode and speed, whether carrier sense drops. A burst with a single-cycle gap just before the limit shows that the timer restarts. Read strobes placed before and on the cycle the sticky flag is set show which of the two wins.

// File: rtl/crs_pkg.sv
package crs_pkg;
  // Strobes from the control to the jabber counter datapath
  typedef struct packed {
    logic cntClear;  // receive activity dropped: restart the count
    logic cntInc;    // receive activity continues below the limit
  } jabStrobe_t;
endpackage

// File: rtl/crs_jabber_dp.sv
module crs_jabber_dp
  import crs_pkg::*;
#(
  parameter int JAB_CYCLES = 18050
) (
  input  logic       clk,
  input  logic       rstN,
  input  jabStrobe_t strobe,
  output logic       atLimit
);
  localparam int CNT_W = $clog2(JAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(JAB_CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  assign atLimit = (cnt == LIMIT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LIMIT);  // R5
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClear |=> (cnt == '0));  // R8
endmodule

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       strapRepeater,
  input  logic       speed100,
  input  logic       rxActive,
  input  logic       txActive,
  input  logic       cfgWr,
  input  logic       cfgRepeater,
  input  logic       cfgOverride,
  input  logic       jabRd,
  input  logic       atLimit,
  output jabStrobe_t strobe,
  output logic       crs,
  output logic       cimEnable,
  output logic       jabberSeen
);
  logic repeaterQ;
  logic overrideQ;
  logic atLimitQ;
  logic cutEnable;
  logic rxPart;
  logic jabOnset;

  // Mode and override bits; the repeater bit takes the strap value in reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      repeaterQ <= strapRepeater;
      overrideQ <= 1'b0;
    end else if (cfgWr) begin
      repeaterQ <= cfgRepeater;
      overrideQ <= cfgOverride;
    end
  end

  // The jabber cut applies unless the repeater hold at 100 Mb/s is in force
  assign cutEnable = !speed100 || !repeaterQ || overrideQ;
  assign rxPart    = rxActive && !(atLimit && cutEnable);
  assign crs       = rxPart || (!repeaterQ && txActive);
  assign cimEnable = speed100 && repeaterQ;

  assign strobe.cntClear = !rxActive;
  assign strobe.cntInc   = rxActive && !atLimit;

  // Sticky flag: set on jabber onset, cleared by a read, set wins
  assign jabOnset = atLimit && !atLimitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      atLimitQ   <= 1'b0;
      jabberSeen <= 1'b0;
    end else begin
      atLimitQ <= atLimit;
      if (jabOnset)   jabberSeen <= 1'b1;
      else if (jabRd) jabberSeen <= 1'b0;
    end
  end

  AST_REP_RX_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (repeaterQ && !rxActive) |-> !crs);  // R1
  AST_NODE_TX: assert property (@(posedge clk) disable iff (!rstN)
    (!repeaterQ && txActive) |-> crs);  // R2
  AST_CIM_10M_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !speed100 |-> !cimEnable);  // R4
  AST_JAB_CUT: assert property (@(posedge clk) disable iff (!rstN)
    (atLimit && cutEnable && (repeaterQ || !txActive)) |-> !crs);  // R5
  AST_REP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxActive && speed100 && repeaterQ && !overrideQ) |-> crs);  // R6
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(atLimit) |=> jabberSeen);  // R9
endmodule

// File: rtl/carrier_sense.sv
module carrier_sense
  import crs_pkg::*;
#(
  parameter int CLK_MHZ = 25,
  parameter int JAB_US  = 722
) (
  input  logic clk,
  input  logic rstN,
  input  logic strapRepeater,
  input  logic speed100,
  input  logic rxActive,
  input  logic txActive,
  input  logic cfgWr,
  input  logic cfgRepeater,
  input  logic cfgOverride,
  input  logic jabRd,
  output logic crs,
  output logic cimEnable,
  output logic jabberSeen
);
  localparam int JAB_CYCLES = CLK_MHZ * JAB_US;

  jabStrobe_t strobe;
  logic       atLimit;

  crs_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .strapRepeater (strapRepeater),
    .speed100      (speed100),
    .rxActive      (rxActive),
    .txActive      (txActive),
    .cfgWr         (cfgWr),
    .cfgRepeater   (cfgRepeater),
    .cfgOverride   (cfgOverride),
    .jabRd         (jabRd),
    .atLimit       (atLimit),
    .strobe        (strobe),
    .crs           (crs),
    .cimEnable     (cimEnable),
    .jabberSeen    (jabberSeen)
  );

  crs_jabber_dp #(.JAB_CYCLES(JAB_CYCLES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .atLimit (atLimit)
  );
endmodule

// File: tb/sim_carrier_sense.sv
module sim_carrier_sense;
  localparam int PERIOD  = 10;
  localparam int CLK_MHZ = 2;
  localparam int JAB_US  = 3;
  localparam int N       = CLK_MHZ * JAB_US;  // 6 cycles to jabber

  logic clk = 1'b0;
  logic rstN, strapRepeater, speed100, rxActive, txActive;
  logic cfgWr, cfgRepeater, cfgOverride, jabRd;
  logic crs, cimEnable, jabberSeen;
  int   nChecks = 0;
  int   nFails  = 0;

  always #(PERIOD/2) clk = ~clk;

  carrier_sense #(.CLK_MHZ(CLK_MHZ), .JAB_US(JAB_US)) u0 (
    .clk(clk), .rstN(rstN), .strapRepeater(strapRepeater),
    .speed100(speed100), .rxActive(rxActive), .txActive(txActive),
    .cfgWr(cfgWr), .cfgRepeater(cfgRepeater), .cfgOverride(cfgOverride),
    .jabRd(jabRd), .crs(crs), .cimEnable(cimEnable), .jabberSeen(jabberSeen)
  );

  // {speed100, repeater, override, rx, tx, expCrs, expCim}
  localparam int NV = 10;
  localparam logic [6:0] VEC [NV] = '{
    7'b0_0_0_1_0_1_0,  // R2 node 10M rx
    7'b0_0_0_0_1_1_0,  // R2 node 10M tx
    7'b1_0_0_0_1_1_0,  // R2 R4 node 100M tx
    7'b1_0_0_0_0_0_0,  // R2 node 100M idle
    7'b1_1_0_0_1_0_1,  // R1 R4 rep 100M tx ignored
    7'b1_1_0_1_0_1_1,  // R1 rep 100M rx
    7'b0_1_0_0_1_0_0,  // R1 R4 rep 10M tx ignored
    7'b0_1_0_1_1_1_0,  // R1 rep 10M rx+tx
    7'b1_1_1_1_1_1_1,  // R1 rep 100M override rx+tx
    7'b1_1_1_0_1_0_1   // R1 rep 100M override tx ignored
  };

  task automatic chk(input logic got, input logic exp, input string req);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; strapRepeater = strap; rxActive = 1'b0; txActive = 1'b0;
    cfgWr = 1'b0; jabRd = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic setCfg(input logic rep, input logic ovr);
    @(negedge clk);
    rxActive = 1'b0; txActive = 1'b0;
    cfgWr = 1'b1; cfgRepeater = rep; cfgOverride = ovr;
    step(1);
    cfgWr = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk);
    rxActive = 1'b0; jabRd = 1'b1;
    step(1);
    jabRd = 1'b0;
  endtask

  // Hold rx for 2N edges and check crs before and after the limit
  task automatic jabberRun(input logic expCut, input string req);
    @(negedge clk);
    rxActive = 1'b1; txActive = 1'b0;
    step(N - 1);
    chk(crs, 1'b1, req);
    step(1);
    chk(crs, !expCut, req);
    step(N);
    chk(crs, !expCut, {req, " R8"});
    chk(jabberSeen, 1'b1, "R9");
    rxActive = 1'b0;
    step(1);
  endtask

  initial begin
    #(PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; strapRepeater = 1'b1; speed100 = 1'b1;
    rxActive = 1'b0; txActive = 1'b0; cfgWr = 1'b0;
    cfgRepeater = 1'b0; cfgOverride = 1'b0; jabRd = 1'b0;

    // Reset with strap high: repeater mode from strap (R3, R10)
    doReset(1'b1);
    chk(cimEnable, 1'b1, "R3 strap repeater");
    chk(jabberSeen, 1'b0, "R10");
    txActive = 1'b1; #1;
    chk(crs, 1'b0, "R3 R1 tx ignored after strap");
    txActive = 1'b0;
    // Reset with strap low: node mode
    doReset(1'b0);
    chk(cimEnable, 1'b0, "R3 strap node");
    txActive = 1'b1; #1;
    chk(crs, 1'b1, "R3 R2 tx after strap");
    txActive = 1'b0;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      setCfg(VEC[i][5], VEC[i][4]);
      speed100 = VEC[i][6]; rxActive = VEC[i][3]; txActive = VEC[i][2];
      #1;
      chk(crs, VEC[i][1], $sformatf("R1/R2 vector %0d crs", i));
      chk(cimEnable, VEC[i][0], $sformatf("R4 vector %0d cim", i));
    end

    // Node 100M jabber, tx still asserts crs during the cut
    speed100 = 1'b1;
    setCfg(1'b0, 1'b0);
    clearFlag();
    @(negedge clk);
    rxActive = 1'b1;
    step(N);
    chk(crs, 1'b0, "R5 node cut");
    chk(jabberSeen, 1'b0, "R9 not yet set");
    step(1);
    chk(jabberSeen, 1'b1, "R9 set after cut");
    txActive = 1'b1; #1;
    chk(crs, 1'b1, "R2 tx during cut");
    txActive = 1'b0;
    step(3);
    chk(crs, 1'b0, "R8 stays low");
    rxActive = 1'b0;
    step(1);
    chk(jabberSeen, 1'b1, "R9 sticky");
    clearFlag();
    chk(jabberSeen, 1'b0, "R9 cleared by read");

    // Node 10M jabber
    speed100 = 1'b0;
    jabberRun(1'b1, "R5 node 10M");
    // Repeater 100M, no override: held
    speed100 = 1'b1;
    setCfg(1'b1, 1'b0);
    clearFlag();
    jabberRun(1'b0, "R6 repeater hold");
    // Repeater 100M, override: cut
    setCfg(1'b1, 1'b1);
    clearFlag();
    jabberRun(1'b1, "R7 override");
    // Repeater 10M, no override: cut
    speed100 = 1'b0;
    setCfg(1'b1, 1'b0);
    clearFlag();
    jabberRun(1'b1, "R7 10M repeater");

    // Single-edge gap restarts the count
    speed100 = 1'b1;
    setCfg(1'b0, 1'b0);
    clearFlag();
    @(negedge clk);
    rxActive = 1'b1;
    step(N - 1);
    rxActive = 1'b0;
    step(1);
    rxActive = 1'b1;
    step(N - 1);
    chk(crs, 1'b1, "R8 gap restarts count");
    step(1);
    chk(crs, 1'b0, "R8 cut after full count");
    rxActive = 1'b0;
    step(1);

    // Read on the same edge as a new onset: set wins
    clearFlag();
    @(negedge clk);
    rxActive = 1'b1;
    step(N);
    jabRd = 1'b1;
    step(1);
    jabRd = 1'b0;
    chk(jabberSeen, 1'b1, "R9 set wins over read");
    rxActive = 1'b0;
    step(1);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule